// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Controller

This block is a synchronous master for an 8192-word by 8-bit asynchronous static RAM. A client presents one read or write request at a time on a valid/ready pair; the controller latches the request, then produces the chip-enable, write-strobe and output-enable waveforms that the memory needs. It also drives and releases the write data, and captures the read data once the memory can deliver it.

All memory timing is given in nanoseconds for three speed grades (150, 170 and 200 ns cycle). Each figure is turned into clock counts by rounding up against the clock-period parameter. A write always begins with the enable, asserts the write strobe one clock later and ends by raising the write strobe while the enable is still low. The zero-hold, zero-recovery case therefore applies. Every finished access is reported with a single-cycle acknowledge; read data appears on the same edge.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is held and after it is released, mem_ce_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0, rsp_ack is 0 and req_ready is 1.
- R2: A read keeps mem_ce_n and mem_oe_n at 0 with mem_we_n at 1 for RD_CYC = max over (cycle time, address access, enable access, output-enable access) of ceil(ns / CLK_PERIOD_NS) clocks (8 at 20 ns, grade 0). On the edge that closes that window, rsp_rdata is loaded from mem_dq_in and rsp_ack is raised, so the acknowledge is seen RD_CYC clocks after the accepting edge.
- R3: In a write, mem_ce_n falls one clock before mem_we_n. mem_we_n stays 0 for max(ceil(tWP), ceil(tDS)) clocks (5 at grade 0) and rises while mem_ce_n is still 0. mem_oe_n stays 1 throughout, so mem_oe_n and mem_we_n are never both 0.
- R4: mem_dq_oe is 1 only while mem_we_n is 0 and during the one clock after mem_we_n rises, which is 6 clocks per write at grade 0. It is never 1 while mem_oe_n is 0.
- R5: A write keeps mem_ce_n low for max(ceil(tWC), WP_CYC + 2) clocks. Its acknowledge is seen that many clocks after the accepting edge (8 at grade 0), with mem_ce_n back at 1.
- R6: mem_addr and mem_dq_out take the request on the accepting edge and do not change while mem_ce_n is 0. A written byte reads back unchanged at the same address, and other addresses keep their contents.
- R7: req_ready is 1 only when no access is in progress. A req_valid seen while req_ready is 0 is dropped: it produces no acknowledge and leaves memory contents unchanged.
- R8: rsp_ack is high for exactly one clock per completed access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Request word address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Controller idle and able to accept |
| rsp_ack | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Captured read byte, valid with rsp_ack |
| mem_addr | output | 13 | Memory address pins |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Enable for the data drivers toward the memory |
| mem_dq_in | input | 8 | Data from the memory |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |

## Verification
If the sequencer counter loads a wrong value, the acknowledge arrives early or late by a measurable number of clocks. In a read, a short count also captures data before the memory model declares it valid, and that corrupt byte shows in rsp_rdata on the same edge. A wrong strobe decode shows up within one clock as an overlap of mem_oe_n and mem_we_n, a write pulse narrower than the setup figures, or drivers enabled outside the strobe window. The memory model records each of these, and a later readback then returns the wrong byte. A request wrongly taken while busy shows up as an extra acknowledge and as a changed byte at the dropped address.

// File: rtl/sram_ctrl_pkg.sv
// Package: timing tables and shared types for the SRAM cycle controller.
// Assumes speed grades 0/1/2 map to 150/170/200 ns parts.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_TAIL,
        ST_RD_WAIT
    } seq_state_e;

    // Round a nanosecond figure up to whole clocks.
    function automatic int unsigned ns_to_clk(int unsigned ns, int unsigned per);
        return (ns + per - 1) / per;
    endfunction

    // Read/write cycle time, address access and enable access share one figure.
    function automatic int unsigned cycle_ns(int unsigned grade);
        case (grade)
            1: return 170;
            2: return 200;
            default: return 150;
        endcase
    endfunction

    // Minimum write strobe width.
    function automatic int unsigned strobe_ns(int unsigned grade);
        case (grade)
            1: return 120;
            2: return 150;
            default: return 100;
        endcase
    endfunction

    // Data setup before the strobe ends.
    function automatic int unsigned setup_ns(int unsigned grade);
        case (grade)
            1: return 70;
            2: return 80;
            default: return 60;
        endcase
    endfunction

    // Output enable to valid data.
    function automatic int unsigned oe_ns(int unsigned grade);
        case (grade)
            1: return 80;
            2: return 100;
            default: return 70;
        endcase
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
// Sequencer: walks each access through its phases, counting clocks per phase,
// and registers the memory strobes from the next state so they never glitch.
// Assumes req_valid is only taken when ready is high.
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 20,
    parameter int unsigned SPEED_GRADE   = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    output logic ready,
    output logic accept,
    output logic capture,
    output logic ack,
    output logic ce_n,
    output logic we_n,
    output logic oe_n,
    output logic dq_oe
);
    localparam int unsigned CYC_C  = ns_to_clk(cycle_ns(SPEED_GRADE), CLK_PERIOD_NS);
    localparam int unsigned OE_C   = ns_to_clk(oe_ns(SPEED_GRADE), CLK_PERIOD_NS);
    localparam int unsigned RD_CYC = max2(CYC_C, OE_C);
    localparam int unsigned WP_CYC = max2(ns_to_clk(strobe_ns(SPEED_GRADE), CLK_PERIOD_NS),
                                          ns_to_clk(setup_ns(SPEED_GRADE), CLK_PERIOD_NS));
    localparam int unsigned TAIL_CYC = (CYC_C > WP_CYC + 2) ? (CYC_C - 1 - WP_CYC) : 1;
    localparam int unsigned MAX_CYC  = max2(RD_CYC, max2(WP_CYC, TAIL_CYC));
    localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LOAD   = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] TAIL_LOAD = CNT_W'(TAIL_CYC - 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             done;

    // Next-state and phase counter selection.
    always_comb begin
        state_d = state_q;
        cnt_d   = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
        accept  = 1'b0;
        capture = 1'b0;
        done    = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept  = 1'b1;
                    state_d = req_write ? ST_WR_SETUP : ST_RD_WAIT;
                    cnt_d   = req_write ? '0 : RD_LOAD;
                end
            end
            ST_WR_SETUP: begin
                state_d = ST_WR_PULSE;
                cnt_d   = WP_LOAD;
            end
            ST_WR_PULSE: begin
                if (cnt_q == '0) begin
                    state_d = ST_WR_TAIL;
                    cnt_d   = TAIL_LOAD;
                end
            end
            ST_WR_TAIL: begin
                if (cnt_q == '0) begin
                    state_d = ST_IDLE;
                    done    = 1'b1;
                end
            end
            ST_RD_WAIT: begin
                if (cnt_q == '0) begin
                    state_d = ST_IDLE;
                    done    = 1'b1;
                    capture = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, counter and registered strobe outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            ce_n    <= 1'b1;
            we_n    <= 1'b1;
            oe_n    <= 1'b1;
            dq_oe   <= 1'b0;
            ack     <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ce_n    <= (state_d == ST_IDLE);
            we_n    <= (state_d != ST_WR_PULSE);
            oe_n    <= (state_d != ST_RD_WAIT);
            dq_oe   <= (state_d == ST_WR_PULSE) || (state_q == ST_WR_PULSE);
            ack     <= done;
        end
    end

    assign ready = (state_q == ST_IDLE);

    // R3: read and write strobes never overlap.
    p_oe_we_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n));
    // R3: the write strobe sits inside the enable window.
    p_we_inside_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !ce_n);
    // R4: data drivers only on with the output buffers of the memory off.
    p_drive_oe_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (oe_n && !ce_n));
    // R8: acknowledge lasts one clock.
    p_ack_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
endmodule

// File: rtl/sram_bus_hold.sv
// Bus holding registers: latch address and write byte on accept, and load the
// read byte on capture. Assumes accept and capture are single-clock pulses.
module sram_bus_hold #(
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic [DATA_W-1:0] rd_data
);
    // Hold the request fields for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
        end
    end

    // Register the memory byte at the end of the read window.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_data <= '0;
        else if (capture) rd_data <= mem_dq_in;
    end
endmodule

// File: rtl/sram_cycle_ctrl.sv
// Top: valid/ready request port to asynchronous SRAM strobes. Assumes the
// memory is 8K x 8 and clocks are no slower than the shortest phase needs.
module sram_cycle_ctrl #(
    parameter int unsigned CLK_PERIOD_NS = 20,
    parameter int unsigned SPEED_GRADE   = 0,
    parameter int unsigned ADDR_W        = 13,
    parameter int unsigned DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_ack,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n
);
    logic accept, capture;

    sram_seq_fsm #(
        .CLK_PERIOD_NS(CLK_PERIOD_NS),
        .SPEED_GRADE  (SPEED_GRADE)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .ready    (req_ready),
        .accept   (accept),
        .capture  (capture),
        .ack      (rsp_ack),
        .ce_n     (mem_ce_n),
        .we_n     (mem_we_n),
        .oe_n     (mem_oe_n),
        .dq_oe    (mem_dq_oe)
    );

    sram_bus_hold #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_dq_in (mem_dq_in),
        .mem_addr  (mem_addr),
        .mem_dq_out(mem_dq_out),
        .rd_data   (rsp_rdata)
    );

    // R6: address and write byte frozen while the enable is low.
    p_addr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));
    // R7: a busy controller never reloads the holding registers.
    p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> $stable(mem_addr));
endmodule

// File: tb/sram_cycle_ctrl_bench.sv
// Directed bench with a behavioural 8K x 8 memory model that checks timing.
module sram_cycle_ctrl_bench;
    localparam int PER    = 20;
    localparam int WP_NS  = 100;
    localparam int DS_NS  = 60;
    localparam int RD_NS  = 150;
    localparam int WC_NS  = 150;
    localparam int EXP_WP  = ((WP_NS + PER - 1) / PER > (DS_NS + PER - 1) / PER) ?
                             (WP_NS + PER - 1) / PER : (DS_NS + PER - 1) / PER;
    localparam int EXP_RD  = (RD_NS + PER - 1) / PER;
    localparam int EXP_WR  = ((WC_NS + PER - 1) / PER > EXP_WP + 2) ?
                             (WC_NS + PER - 1) / PER : EXP_WP + 2;
    localparam int EXP_DRV = EXP_WP + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [12:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_ack, mem_dq_oe, mem_ce_n, mem_we_n, mem_oe_n;
    logic [7:0]  rsp_rdata, mem_dq_out;
    logic [7:0]  mem_dq_in = '0;
    logic [12:0] mem_addr;

    int total = 0, bad = 0;

    always #10 clk = ~clk;

    sram_cycle_ctrl u_sram_cycle_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n)
    );

    // ---------------- memory model ----------------
    logic [7:0]  mem [0:8191];
    int          rd_cnt, wp_cnt, ds_cnt, drv_cnt, last_wp, last_drv;
    int          viol_r3, viol_r4, viol_r6;
    logic        prev_wr, prev_ce_low, prev_we_low;
    logic [12:0] wr_addr, prev_addr;
    logic [7:0]  wr_data;

    function automatic logic [7:0] init_val(logic [12:0] a);
        return a[7:0] ^ 8'h3C;
    endfunction

    // Model: samples pins away from the rising edge, stores, serves and flags.
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8192; i++) mem[i] = init_val(13'(i));
            rd_cnt = 0; wp_cnt = 0; ds_cnt = 0; drv_cnt = 0;
            last_wp = 0; last_drv = 0;
            viol_r3 = 0; viol_r4 = 0; viol_r6 = 0;
            prev_wr = 0; prev_ce_low = 0; prev_we_low = 0;
            wr_addr = '0; prev_addr = '0; wr_data = '0;
        end else begin
            if (!mem_ce_n && prev_ce_low && mem_addr != prev_addr) viol_r6++;
            if (!mem_oe_n && !mem_we_n) viol_r3++;
            if (!mem_we_n && !prev_we_low && !prev_ce_low) viol_r3++;
            if (mem_dq_oe && !mem_oe_n) viol_r4++;
            if (mem_dq_oe && mem_we_n && !prev_we_low) viol_r4++;
            if (!mem_we_n && !mem_dq_oe) viol_r4++;
            if (!mem_ce_n && mem_dq_oe) drv_cnt++;
            if (mem_ce_n && prev_ce_low) begin
                last_drv = drv_cnt;
                drv_cnt  = 0;
            end
            // write tracking
            if (!mem_ce_n && !mem_we_n) begin
                if (!prev_wr) begin
                    wr_addr = mem_addr; wr_data = mem_dq_out; wp_cnt = 1; ds_cnt = 1;
                end else begin
                    wp_cnt++;
                    if (mem_addr != wr_addr) viol_r6++;
                    if (mem_dq_out == wr_data) ds_cnt++;
                    else begin ds_cnt = 1; wr_data = mem_dq_out; end
                end
                prev_wr = 1;
            end else if (prev_wr) begin
                if (wp_cnt * PER < WP_NS) viol_r3++;
                if (ds_cnt * PER < DS_NS) viol_r3++;
                mem[wr_addr] = wr_data;
                last_wp = wp_cnt;
                prev_wr = 0;
            end
            // read serving: corrupt data until access time has elapsed
            if (!mem_ce_n && !mem_oe_n && mem_we_n &&
                (rd_cnt == 0 || mem_addr == prev_addr)) rd_cnt++;
            else rd_cnt = 0;
            mem_dq_in = (rd_cnt * PER >= RD_NS) ? mem[mem_addr] : ~mem[mem_addr];
            prev_ce_low = !mem_ce_n;
            prev_we_low = !mem_we_n;
            prev_addr   = mem_addr;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Issue one request and return clocks from accepting edge to acknowledge.
    task automatic issue(input bit wr, input logic [12:0] a, input logic [7:0] d,
                         output int lat);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!rsp_ack && lat < 50);
        #1;
    endtask

    task automatic do_write(input logic [12:0] a, input logic [7:0] d);
        int lat;
        issue(1'b1, a, d, lat);
        chk(lat == EXP_WR, "R5", "write ack latency", lat, EXP_WR);
        chk(mem_ce_n == 1'b1, "R5", "enable high at ack", int'(mem_ce_n), 1);
        chk(last_wp == EXP_WP, "R3", "write strobe width", last_wp, EXP_WP);
        chk(last_drv == EXP_DRV, "R4", "drive window", last_drv, EXP_DRV);
        @(negedge clk);
        chk(rsp_ack == 1'b0, "R8", "ack width", int'(rsp_ack), 0);
    endtask

    task automatic do_read(input logic [12:0] a, input logic [7:0] exp);
        int lat;
        issue(1'b0, a, 8'h00, lat);
        chk(lat == EXP_RD, "R2", "read ack latency", lat, EXP_RD);
        chk(rsp_rdata == exp, "R2", "read data", int'(rsp_rdata), int'(exp));
        @(negedge clk);
        chk(rsp_ack == 1'b0, "R8", "ack width", int'(rsp_ack), 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk({mem_ce_n, mem_we_n, mem_oe_n} == 3'b111, "R1", "strobes idle",
            int'({mem_ce_n, mem_we_n, mem_oe_n}), 7);
        chk(!mem_dq_oe && !rsp_ack, "R1", "drive/ack off",
            int'({mem_dq_oe, rsp_ack}), 0);
        chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
    endtask

    task automatic t_patterns;
        do_write(13'h0000, 8'hA5);
        do_read (13'h0000, 8'hA5);
        do_write(13'h1FFF, 8'h00);
        do_read (13'h1FFF, 8'h00);
        do_write(13'h0AAA, 8'hFF);
        do_read (13'h1555, init_val(13'h1555));   // R6 neighbour untouched
        do_read (13'h0AAA, 8'hFF);                // R6 readback
        do_read (13'h0123, init_val(13'h0123));
    endtask

    task automatic t_busy_ignore;
        int extra = 0;
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 13'h0040; req_wdata = 8'h11;
        @(negedge clk);
        req_valid = 0;
        @(negedge clk);
        chk(req_ready == 1'b0, "R7", "ready low while busy", int'(req_ready), 0);
        req_valid = 1; req_write = 1; req_addr = 13'h0041; req_wdata = 8'h77;
        @(negedge clk);
        req_valid = 0;
        for (int i = 0; i < EXP_WR + 14; i++) begin
            @(negedge clk);
            if (rsp_ack) extra++;
        end
        chk(extra == 1, "R7", "acks for one accepted plus one dropped", extra, 1);
        do_read(13'h0041, init_val(13'h0041));
        do_read(13'h0040, 8'h11);
    endtask

    task automatic t_model_clean;
        chk(viol_r3 == 0, "R3", "strobe timing violations", viol_r3, 0);
        chk(viol_r4 == 0, "R4", "drive window violations", viol_r4, 0);
        chk(viol_r6 == 0, "R6", "address hold violations", viol_r6, 0);
    endtask

    initial begin
        t_reset();
        t_patterns();
        t_busy_ignore();
        t_model_clean();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule